// File: doc/BRIEF.md
# Learning MAC Address Table

This block is the forwarding table of a small layer-2 switch. Each of its entries holds a 48-bit MAC address, a one-hot mask of output ports and a lock flag. The datapath uses the table in two ways. A lookup port presents a destination MAC and, one cycle later, gets back a hit flag and the port mask of the matching entry. A learn port presents a source MAC and the port it arrived on, and the table records that pairing in an unlocked entry. Two counters record how many lookups hit and how many missed.

Software never addresses an entry's storage directly. It writes two shared 32-bit data words, the high word and the low word. Writing an index to the load strobe copies that entry into the data words. Writing an index to the commit strobe copies the data words into that entry. Reads and writes use the same pair of data words but have separate index strobes.

An entry takes part in matching only when its port mask is nonzero. A table reset to all zeros is therefore empty.

Top module: `mac_learn_table`

## Requirements
- R1: A write strobe on the high or low data word sets that word, and the word reads back on the next cycle. If an index load happens in the same cycle, the load takes priority over the data write.
- R2: High data word layout: bit 31 is the lock flag (1 = protected from learning), bits 30..16 are the one-hot port mask, and bits 15..0 are MAC[47:32]. The low data word is MAC[31:0].
- R3: An index load copies the selected entry into both data words, visible on the next cycle.
- R4: An index commit stores the current data words into the selected entry. Lookups see the new contents from the next cycle on.
- R5: One cycle after a lookup request the response valid is high. If an entry has an equal MAC and a nonzero mask, hit is 1 and the port mask is that entry's mask. Otherwise hit is 0 and the mask is 0. Without a request, valid and hit are 0.
- R6: When several entries match a lookup, the entry with the lowest index answers.
- R7: Each lookup adds exactly one to either the hit counter or the miss counter. Both counters are 0 after reset.
- R8: A learn whose MAC matches an unlocked entry rewrites that entry with the learned MAC, a mask holding only the ingress port bit, and lock 0.
- R9: A learn whose first matching entry is locked changes nothing.
- R10: A learn that matches no entry writes into the first unlocked entry at or after a round-robin pointer, which starts at 0 after reset. The pointer then moves to the entry after the one written. If every entry is locked, the learn is dropped.
- R11: A learn whose ingress port is NUM_PORTS or greater is ignored, and the round-robin pointer does not move.
- R12: A commit and a learn that target the same entry in the same cycle leave the committed data in that entry.
- R13: After reset every entry, both data words, both counters and all lookup outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_hi_we | input | 1 | Write sw_wdata into the high data word |
| sw_lo_we | input | 1 | Write sw_wdata into the low data word |
| sw_wdata | input | 32 | Software write data |
| sw_rd_idx_we | input | 1 | Load entry sw_idx into the data words |
| sw_wr_idx_we | input | 1 | Commit the data words into entry sw_idx |
| sw_idx | input | IDX_W | Entry index for load or commit |
| sw_hi_rdata | output | 32 | High data word |
| sw_lo_rdata | output | 32 | Low data word |
| hit_count | output | CNT_W | Lookup hit counter |
| miss_count | output | CNT_W | Lookup miss counter |
| lk_valid | input | 1 | Lookup request |
| lk_mac | input | 48 | Destination MAC to look up |
| lk_rsp_valid | output | 1 | Lookup response valid |
| lk_hit | output | 1 | Lookup found an entry |
| lk_port_mask | output | 15 | Port mask of the answering entry |
| ln_valid | input | 1 | Learn request |
| ln_mac | input | 48 | Source MAC to learn |
| ln_port | input | 4 | Ingress port number |

## Verification
The checker tests four rules on every cycle. A lookup gets its response exactly one cycle later. Hit agrees with a nonzero mask. The two counters together step by one per lookup, and stay still when there is none. A data-word write lands unless an index load happens in the same cycle. What the table holds can only be seen through scenarios: lowest-index priority, learn rewrites, lock protection, the path of the round-robin victim pointer and the commit-over-learn collision. The bench checks these by loading entries back and by looking up against a model of the table.

// File: rtl/mac_tbl_pkg.sv
package mac_tbl_pkg;
    localparam int MASK_W     = 15;
    localparam int MAC_W      = 48;
    localparam int WORD_W     = 32;
    localparam int PORT_SEL_W = 4;

    // Packed so that {high word, low word} maps straight onto an entry.
    typedef struct packed {
        logic              locked;
        logic [MASK_W-1:0] ports;
        logic [MAC_W-1:0]  mac;
    } tbl_entry_t;
endpackage

// File: rtl/mac_tbl_match.sv
module mac_tbl_match
    import mac_tbl_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES-1:0][MAC_W-1:0] entry_mac,
    input  logic [NUM_ENTRIES-1:0]            entry_live,
    input  logic [MAC_W-1:0]                  key,
    output logic                              found,
    output logic [IDX_W-1:0]                  idx
);
    logic [NUM_ENTRIES-1:0] hit_vec;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = entry_live[g] && (entry_mac[g] == key);
    end

    // Walk down from the top so the lowest matching index is assigned last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/mac_tbl_victim.sv
module mac_tbl_victim #(
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES-1:0] locked,
    input  logic [IDX_W-1:0]       start,
    output logic                   found,
    output logic [IDX_W-1:0]       idx
);
    // First unlocked entry at or after start, wrapping around.
    always_comb begin
        int cand;
        found = 1'b0;
        idx   = '0;
        cand  = 0;
        for (int k = NUM_ENTRIES - 1; k >= 0; k--) begin
            cand = (int'(start) + k) % NUM_ENTRIES;
            if (!locked[cand]) begin
                found = 1'b1;
                idx   = IDX_W'(cand);
            end
        end
    end
endmodule

// File: rtl/mac_learn_table.sv
module mac_learn_table
    import mac_tbl_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_PORTS   = 8,
    parameter int CNT_W       = 32,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sw_hi_we,
    input  logic                  sw_lo_we,
    input  logic [WORD_W-1:0]     sw_wdata,
    input  logic                  sw_rd_idx_we,
    input  logic                  sw_wr_idx_we,
    input  logic [IDX_W-1:0]      sw_idx,
    output logic [WORD_W-1:0]     sw_hi_rdata,
    output logic [WORD_W-1:0]     sw_lo_rdata,
    output logic [CNT_W-1:0]      hit_count,
    output logic [CNT_W-1:0]      miss_count,
    input  logic                  lk_valid,
    input  logic [MAC_W-1:0]      lk_mac,
    output logic                  lk_rsp_valid,
    output logic                  lk_hit,
    output logic [MASK_W-1:0]     lk_port_mask,
    input  logic                  ln_valid,
    input  logic [MAC_W-1:0]      ln_mac,
    input  logic [PORT_SEL_W-1:0] ln_port
);
    typedef struct packed {
        tbl_entry_t [NUM_ENTRIES-1:0] tbl;
        logic [WORD_W-1:0]            hi;
        logic [WORD_W-1:0]            lo;
        logic [IDX_W-1:0]             rr;
        logic [CNT_W-1:0]             hits;
        logic [CNT_W-1:0]             misses;
        logic                         rsp_v;
        logic                         rsp_hit;
        logic [MASK_W-1:0]            rsp_mask;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_ENTRIES-1:0][MAC_W-1:0] mac_vec;
    logic [NUM_ENTRIES-1:0]            live_vec;
    logic [NUM_ENTRIES-1:0]            lock_vec;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_vec
        assign mac_vec[g]  = st_q.tbl[g].mac;
        assign live_vec[g] = |st_q.tbl[g].ports;
        assign lock_vec[g] = st_q.tbl[g].locked;
    end

    logic             lk_found, ln_found, vic_found;
    logic [IDX_W-1:0] lk_idx, ln_idx, vic_idx;

    mac_tbl_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_lk_match (
        .entry_mac  (mac_vec),
        .entry_live (live_vec),
        .key        (lk_mac),
        .found      (lk_found),
        .idx        (lk_idx)
    );

    mac_tbl_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_ln_match (
        .entry_mac  (mac_vec),
        .entry_live (live_vec),
        .key        (ln_mac),
        .found      (ln_found),
        .idx        (ln_idx)
    );

    mac_tbl_victim #(.NUM_ENTRIES(NUM_ENTRIES)) u_victim (
        .locked (lock_vec),
        .start  (st_q.rr),
        .found  (vic_found),
        .idx    (vic_idx)
    );

    always_comb begin
        tbl_entry_t learned;
        logic       ln_ok;

        st_d = st_q;

        // Lookup response and counters.
        st_d.rsp_v    = lk_valid;
        st_d.rsp_hit  = 1'b0;
        st_d.rsp_mask = '0;
        if (lk_valid) begin
            if (lk_found) begin
                st_d.rsp_hit  = 1'b1;
                st_d.rsp_mask = st_q.tbl[lk_idx].ports;
                st_d.hits     = st_q.hits + 1'b1;
            end else begin
                st_d.misses   = st_q.misses + 1'b1;
            end
        end

        // Learning.
        ln_ok          = ln_valid && (int'(ln_port) < NUM_PORTS);
        learned.locked = 1'b0;
        learned.ports  = MASK_W'(1) << ln_port;
        learned.mac    = ln_mac;
        if (ln_ok) begin
            if (ln_found) begin
                if (!st_q.tbl[ln_idx].locked) begin
                    st_d.tbl[ln_idx] = learned;
                end
            end else if (vic_found) begin
                st_d.tbl[vic_idx] = learned;
                if (int'(vic_idx) == NUM_ENTRIES - 1) begin
                    st_d.rr = '0;
                end else begin
                    st_d.rr = vic_idx + 1'b1;
                end
            end
        end

        // Software commit comes after learning so it wins a collision.
        if (sw_wr_idx_we) begin
            st_d.tbl[sw_idx] = tbl_entry_t'({st_q.hi, st_q.lo});
        end

        // Data words: an index load overrides a same-cycle data write.
        if (sw_hi_we) st_d.hi = sw_wdata;
        if (sw_lo_we) st_d.lo = sw_wdata;
        if (sw_rd_idx_we) begin
            {st_d.hi, st_d.lo} = st_q.tbl[sw_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sw_hi_rdata  = st_q.hi;
    assign sw_lo_rdata  = st_q.lo;
    assign hit_count    = st_q.hits;
    assign miss_count   = st_q.misses;
    assign lk_rsp_valid = st_q.rsp_v;
    assign lk_hit       = st_q.rsp_hit;
    assign lk_port_mask = st_q.rsp_mask;
endmodule

// File: rtl/mac_tbl_checker.sv
module mac_tbl_checker
    import mac_tbl_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              lk_rsp_valid,
    input logic              lk_hit,
    input logic [MASK_W-1:0] lk_port_mask,
    input logic [CNT_W-1:0]  hit_count,
    input logic [CNT_W-1:0]  miss_count,
    input logic              sw_hi_we,
    input logic              sw_rd_idx_we,
    input logic [WORD_W-1:0] sw_wdata,
    input logic [WORD_W-1:0] sw_hi_rdata
);
    logic [CNT_W-1:0] total;
    assign total = hit_count + miss_count;

    // R5
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> lk_rsp_valid);

    // R5
    no_req_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!lk_rsp_valid && !lk_hit));

    // R5
    hit_mask_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_rsp_valid |-> (lk_hit == (lk_port_mask != '0)));

    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (total == CNT_W'($past(total) + 1'b1)));

    // R7
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> ($stable(hit_count) && $stable(miss_count)));

    // R1
    hi_word_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_hi_we && !sw_rd_idx_we) |=> (sw_hi_rdata == $past(sw_wdata)));
endmodule

bind mac_learn_table mac_tbl_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .lk_rsp_valid (lk_rsp_valid),
    .lk_hit       (lk_hit),
    .lk_port_mask (lk_port_mask),
    .hit_count    (hit_count),
    .miss_count   (miss_count),
    .sw_hi_we     (sw_hi_we),
    .sw_rd_idx_we (sw_rd_idx_we),
    .sw_wdata     (sw_wdata),
    .sw_hi_rdata  (sw_hi_rdata)
);

// File: tb/tb_mac_learn_table.sv
module tb_mac_learn_table;
    localparam int N  = 16;
    localparam int NP = 8;
    localparam int CW = 32;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sw_hi_we = 0, sw_lo_we = 0, sw_rd_idx_we = 0, sw_wr_idx_we = 0;
    logic [31:0]   sw_wdata = '0;
    logic [IW-1:0] sw_idx = '0;
    logic [31:0]   sw_hi_rdata, sw_lo_rdata;
    logic [CW-1:0] hit_count, miss_count;
    logic          lk_valid = 0;
    logic [47:0]   lk_mac = '0;
    logic          lk_rsp_valid, lk_hit;
    logic [14:0]   lk_port_mask;
    logic          ln_valid = 0;
    logic [47:0]   ln_mac = '0;
    logic [3:0]    ln_port = '0;

    mac_learn_table #(.NUM_ENTRIES(N), .NUM_PORTS(NP), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n),
        .sw_hi_we(sw_hi_we), .sw_lo_we(sw_lo_we), .sw_wdata(sw_wdata),
        .sw_rd_idx_we(sw_rd_idx_we), .sw_wr_idx_we(sw_wr_idx_we), .sw_idx(sw_idx),
        .sw_hi_rdata(sw_hi_rdata), .sw_lo_rdata(sw_lo_rdata),
        .hit_count(hit_count), .miss_count(miss_count),
        .lk_valid(lk_valid), .lk_mac(lk_mac), .lk_rsp_valid(lk_rsp_valid),
        .lk_hit(lk_hit), .lk_port_mask(lk_port_mask),
        .ln_valid(ln_valid), .ln_mac(ln_mac), .ln_port(ln_port)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Model of the table: [63] lock, [62:48] mask, [47:0] MAC (R2 layout).
    logic [63:0] m_tbl [N];
    logic [31:0] m_hi, m_lo;
    int          m_rr, m_hits, m_misses;
    logic [47:0] pool [8];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int m_find(input logic [47:0] mac);
        for (int i = 0; i < N; i++)
            if (m_tbl[i][47:0] == mac && m_tbl[i][62:48] != 0) return i;
        return -1;
    endfunction

    function automatic void m_learn(input logic [47:0] mac, input int port);
        int f;
        if (port >= NP) return;                         // R11
        f = m_find(mac);
        if (f >= 0) begin
            if (!m_tbl[f][63]) m_tbl[f] = {1'b0, 15'(1) << port, mac};  // R8, R9
            return;
        end
        for (int k = 0; k < N; k++) begin               // R10
            int c;
            c = (m_rr + k) % N;
            if (!m_tbl[c][63]) begin
                m_tbl[c] = {1'b0, 15'(1) << port, mac};
                m_rr = (c + 1) % N;
                return;
            end
        end
    endfunction

    task automatic sw_hi(input logic [31:0] v);
        sw_hi_we = 1; sw_wdata = v;
        @(negedge clk);
        sw_hi_we = 0;
        m_hi = v;
        chk("R1 high word", 64'(sw_hi_rdata), 64'(v));
    endtask

    task automatic sw_lo(input logic [31:0] v);
        sw_lo_we = 1; sw_wdata = v;
        @(negedge clk);
        sw_lo_we = 0;
        m_lo = v;
        chk("R1 low word", 64'(sw_lo_rdata), 64'(v));
    endtask

    task automatic sw_commit(input int idx);
        sw_wr_idx_we = 1; sw_idx = IW'(idx);
        @(negedge clk);
        sw_wr_idx_we = 0;
        m_tbl[idx] = {m_hi, m_lo};
    endtask

    task automatic sw_read(input int idx, input string tag);
        sw_rd_idx_we = 1; sw_idx = IW'(idx);
        @(negedge clk);
        sw_rd_idx_we = 0;
        {m_hi, m_lo} = m_tbl[idx];
        chk({tag, " hi"}, 64'(sw_hi_rdata), 64'(m_hi));
        chk({tag, " lo"}, 64'(sw_lo_rdata), 64'(m_lo));
    endtask

    task automatic sw_put(input int idx, input bit lock, input logic [14:0] mask, input logic [47:0] mac);
        sw_hi({lock, mask, mac[47:32]});
        sw_lo(mac[31:0]);
        sw_commit(idx);
    endtask

    task automatic lookup(input logic [47:0] mac, input string tag);
        int f;
        lk_valid = 1; lk_mac = mac;
        @(negedge clk);
        lk_valid = 0;
        f = m_find(mac);
        if (f >= 0) m_hits++; else m_misses++;
        chk({tag, " rsp_valid"}, 64'(lk_rsp_valid), 64'(1));
        chk({tag, " hit"}, 64'(lk_hit), 64'(f >= 0));
        chk({tag, " mask"}, 64'(lk_port_mask), (f >= 0) ? 64'(m_tbl[f][62:48]) : 64'(0));
        chk("R7 hits", 64'(hit_count), 64'(m_hits));
        chk("R7 misses", 64'(miss_count), 64'(m_misses));
    endtask

    task automatic learn(input logic [47:0] mac, input int port);
        ln_valid = 1; ln_mac = mac; ln_port = 4'(port);
        @(negedge clk);
        ln_valid = 0;
        m_learn(mac, port);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) m_tbl[i] = '0;
        for (int i = 0; i < 8; i++) pool[i] = 48'h0200_0000_0000 + 48'(i) * 48'h0101_1111;
        m_hi = 0; m_lo = 0; m_rr = 0; m_hits = 0; m_misses = 0;

        repeat (3) @(negedge clk);
        rst_n = 1;
        // R13 reset state
        chk("R13 hi", 64'(sw_hi_rdata), 0);
        chk("R13 lo", 64'(sw_lo_rdata), 0);
        chk("R13 hits", 64'(hit_count), 0);
        chk("R13 misses", 64'(miss_count), 0);
        chk("R13 rsp", 64'({lk_rsp_valid, lk_hit, lk_port_mask}), 0);
        sw_read(5, "R13 entry");
        lookup(48'h0, "R13 empty lookup");

        // R2 R3 R4 R5: commit, load back, lookup
        sw_put(3, 0, 15'h0010, 48'haabb_ccdd_eeff);
        sw_hi(32'h1234_5678);
        sw_read(3, "R3 load");
        chk("R2 mask field", 64'(sw_hi_rdata[30:16]), 64'h10);
        chk("R2 mac high", 64'(sw_hi_rdata[15:0]), 64'haabb);
        lookup(48'haabb_ccdd_eeff, "R4 R5 hit");
        lookup(48'haabb_ccdd_eefe, "R5 miss");

        // R6 lowest index wins
        sw_put(7, 0, 15'h0002, pool[1]);
        sw_put(5, 0, 15'h0004, pool[1]);
        lookup(pool[1], "R6 priority");

        // R8 learn rewrites unlocked match
        learn(48'haabb_ccdd_eeff, 2);
        sw_read(3, "R8 relearn");

        // R9 locked match untouched
        sw_put(9, 1, 15'h0001, pool[2]);
        learn(pool[2], 5);
        sw_read(9, "R9 locked");
        lookup(pool[2], "R9 lookup");

        // R10 victim pointer skipping locked entries
        learn(pool[3], 1);
        sw_put(1, 1, 15'h0008, pool[4]);
        sw_put(2, 1, 15'h0008, pool[5]);
        learn(pool[6], 0);
        sw_read(3, "R10 victim");
        sw_read(1, "R10 locked kept");

        // R11 out-of-range port ignored, pointer unmoved
        learn(48'h0000_dead_beef, 9);
        lookup(48'h0000_dead_beef, "R11 ignored");
        learn(pool[7], 3);
        sw_read(4, "R11 pointer");

        // R12 commit beats learn on the same entry
        sw_hi({1'b1, 15'h0100, 16'h0abc});
        sw_lo(32'h0102_0304);
        ln_valid = 1; ln_mac = pool[7]; ln_port = 4'd6;
        sw_wr_idx_we = 1; sw_idx = 4'd4;
        @(negedge clk);
        ln_valid = 0; sw_wr_idx_we = 0;
        m_learn(pool[7], 6);
        m_tbl[4] = {m_hi, m_lo};
        sw_read(4, "R12 collision");

        // R1 index load beats same-cycle data write
        sw_hi_we = 1; sw_wdata = 32'hffff_0000; sw_rd_idx_we = 1; sw_idx = 4'd9;
        @(negedge clk);
        sw_hi_we = 0; sw_rd_idx_we = 0;
        {m_hi, m_lo} = m_tbl[9];
        chk("R1 load priority", 64'(sw_hi_rdata), 64'(m_hi));

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 3)
                learn(pool[$urandom_range(0, 7)], int'($urandom_range(0, 9)));
            else if (op < 6)
                lookup(pool[$urandom_range(0, 7)], "R5 R6 random lookup");
            else if (op < 8)
                sw_put(int'($urandom_range(0, N - 1)), ($urandom_range(0, 3) == 0),
                       15'($urandom_range(0, 3) == 0 ? 0 : (1 << $urandom_range(0, 14))),
                       pool[$urandom_range(0, 7)]);
            else
                sw_read(int'($urandom_range(0, N - 1)), "R3 R8 R10 random read");
        end
        for (int i = 0; i < N; i++) sw_read(i, "R4 final contents");

        // R10 all entries locked: learn dropped
        for (int i = 0; i < N; i++) sw_put(i, 1, 15'h0001, pool[0]);
        learn(48'h0000_0bad_f00d, 1);
        lookup(48'h0000_0bad_f00d, "R10 all locked");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule